// File: doc/BRIEF.md
# Serial EEPROM Read Responder

This block plays the device side of a three-wire serial EEPROM link that a host drives bit by bit from software. The host toggles a serial clock and presents a data-in level. The block samples that level on every rising serial-clock edge. It recognises a command as a start bit, a two-bit operation code and a six-bit word address. It then shifts a 16-bit word back to the host on the data-out line, most significant bit first.

The word store is not a memory. Three fixed word addresses each return one byte pair of a 48-bit station address. The station address arrives on a parallel input. The serial clock is asynchronous to the system clock, so it is sampled and edge-detected in the system clock domain. Malformed commands do not stop the block. Each one sets a sticky error flag and returns the block to waiting for a start bit.

Top module: `mw_eeprom_resp`

## Requirements
- R1: While rst_n is low, and after reset is released, do_o is 0 and err_o is 0, and the block waits for a start bit.
- R2: While the block waits for a start bit, it ignores rising serial-clock edges that sample di_i low. The first rising edge that samples di_i high begins a command.
- R3: The next two rising edges shift in the operation code, MSB first. Only binary 10 (read) is accepted. Any other code sets err_o, returns the block to waiting for a start bit, and produces no data.
- R4: The six rising edges after that shift in the word address, MSB first. Byte n is station_addr_i[8n+7:8n]. Address 8 returns {byte5, byte4}, address 7 returns {byte3, byte2}, and address 6 returns {byte1, byte0}.
- R5: An address of 12 or higher, which lies beyond the store, sets err_o, returns the block to waiting, and produces no data.
- R6: An address below 12 that is not 6, 7 or 8 sets err_o, returns the block to waiting, and produces no data.
- R7: On each of the 16 rising edges that follow a valid address, do_o takes the next bit of the word, MSB first. di_i is ignored during these edges. The word is captured when the last address bit arrives, so later changes to station_addr_i do not alter it.
- R8: On every rising edge outside the data phase, do_o is driven to 0. The last data bit is therefore held until the next rising edge, which clears do_o.
- R9: Once set, err_o stays set until reset, and later valid reads still work.
- R10: Only low-to-high transitions of sk_i count. A serial clock held high, and a falling edge, change nothing. do_o and err_o follow a rising edge of sk_i within three system clock cycles.
- R11: The rising edge that follows the 16th data bit can itself be the start bit of the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sk_i | input | 1 | Serial clock from the host, asynchronous |
| di_i | input | 1 | Serial data from the host |
| station_addr_i | input | 48 | Station address; byte n is bits 8n+7:8n |
| do_o | output | 1 | Serial data to the host |
| err_o | output | 1 | Sticky flag for a malformed command |

## Verification
One serial edge can do two jobs at once: clear the last data bit of a read, and sample the start bit of the next command. The bench provokes this by issuing reads back to back, with no idle bits between them. It judges the result by expecting do_o to be 0 after that edge and the next word to come out intact. A second overlap is a word capture paired with a station-address change on the following edge. The bench flips every station bit right after the last address bit and expects the word captured before the flip.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int MW_OPC_W  = 2;
    localparam int MW_ADDR_W = 6;
    localparam int MW_WORD_W = 16;
    localparam int MW_CNT_W  = $clog2(MW_WORD_W + 1);

    localparam logic [MW_OPC_W-1:0] MW_OP_READ = 2'b10;

    typedef enum logic [1:0] {
        MW_IDLE,
        MW_OPC,
        MW_ADR,
        MW_RD
    } mw_state_e;

    typedef struct packed {
        mw_state_e              state;
        logic [MW_CNT_W-1:0]    cnt;
        logic [MW_OPC_W-1:0]    opc;
        logic [MW_ADDR_W-1:0]   adr;
        logic [MW_WORD_W-1:0]   shreg;
        logic                   dout;
        logic                   err;
    } mw_regs_t;
endpackage

// File: rtl/mw_edge_sync.sv
module mw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sk_i,
    input  logic di_i,
    output logic rise_o,
    output logic di_o
);
    logic [STAGES-1:0] sk_pipe_q, sk_pipe_d;
    logic [STAGES-1:0] di_pipe_q, di_pipe_d;
    logic              sk_prev_q, sk_prev_d;

    generate
        if (STAGES == 1) begin : g_one
            assign sk_pipe_d = sk_i;
            assign di_pipe_d = di_i;
        end else begin : g_many
            assign sk_pipe_d = {sk_pipe_q[STAGES-2:0], sk_i};
            assign di_pipe_d = {di_pipe_q[STAGES-2:0], di_i};
        end
    endgenerate

    assign sk_prev_d = sk_pipe_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_pipe_q <= '0;
            di_pipe_q <= '0;
            sk_prev_q <= 1'b0;
        end else begin
            sk_pipe_q <= sk_pipe_d;
            di_pipe_q <= di_pipe_d;
            sk_prev_q <= sk_prev_d;
        end
    end

    // rising edge of the synchronized serial clock; data aligned to it
    assign rise_o = sk_pipe_q[STAGES-1] & ~sk_prev_q;
    assign di_o   = di_pipe_q[STAGES-1];
endmodule

// File: rtl/mw_word_map.sv
module mw_word_map #(
    parameter int ADDR_W        = 6,
    parameter int WORD_W        = 16,
    parameter int STATION_BYTES = 6,
    parameter int STORE_WORDS   = 12,
    parameter int BASE_ADDR     = 6
) (
    input  logic [ADDR_W-1:0]          adr_i,
    input  logic [8*STATION_BYTES-1:0] station_i,
    output logic [WORD_W-1:0]          word_o,
    output logic                       ok_o
);
    localparam int N_WORDS = (8 * STATION_BYTES) / WORD_W;

    logic [N_WORDS-1:0] hit;
    logic [WORD_W-1:0]  pick [N_WORDS];
    logic               in_range;

    // slot k sits at BASE_ADDR+k and carries station bits WORD_W*k upward
    for (genvar k = 0; k < N_WORDS; k++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADR = ADDR_W'(BASE_ADDR + k);
        assign hit[k]  = (adr_i == SLOT_ADR);
        assign pick[k] = hit[k] ? station_i[WORD_W*k +: WORD_W] : '0;
    end

    always_comb begin
        word_o = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            word_o = word_o | pick[k];
        end
    end

    assign in_range = ({1'b0, adr_i} < (ADDR_W+1)'(STORE_WORDS));
    assign ok_o     = (|hit) & in_range;
endmodule

// File: rtl/mw_serial_fsm.sv
module mw_serial_fsm
    import mw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_i,
    input  logic                 di_i,
    input  logic [MW_WORD_W-1:0] map_word_i,
    input  logic                 map_ok_i,
    output logic [MW_ADDR_W-1:0] adr_shift_o,
    output mw_state_e            state_o,
    output logic                 dout_o,
    output logic                 err_o
);
    mw_regs_t q, d;

    localparam logic [MW_CNT_W-1:0] ONE = MW_CNT_W'(1);

    // address including the bit arriving on this edge, fed to the map
    assign adr_shift_o = {q.adr[MW_ADDR_W-2:0], di_i};

    always_comb begin
        d = q;
        if (rise_i) begin
            d.dout = 1'b0;
            unique case (q.state)
                MW_IDLE: begin
                    if (di_i) begin
                        d.state = MW_OPC;
                        d.cnt   = MW_CNT_W'(MW_OPC_W);
                        d.opc   = '0;
                    end
                end
                MW_OPC: begin
                    d.opc = {q.opc[MW_OPC_W-2:0], di_i};
                    d.cnt = q.cnt - ONE;
                    if (q.cnt == ONE) begin
                        if ({q.opc[MW_OPC_W-2:0], di_i} == MW_OP_READ) begin
                            d.state = MW_ADR;
                            d.cnt   = MW_CNT_W'(MW_ADDR_W);
                            d.adr   = '0;
                        end else begin
                            d.state = MW_IDLE;
                            d.err   = 1'b1;
                        end
                    end
                end
                MW_ADR: begin
                    d.adr = adr_shift_o;
                    d.cnt = q.cnt - ONE;
                    if (q.cnt == ONE) begin
                        if (map_ok_i) begin
                            d.state = MW_RD;
                            d.cnt   = MW_CNT_W'(MW_WORD_W);
                            d.shreg = map_word_i;
                        end else begin
                            d.state = MW_IDLE;
                            d.err   = 1'b1;
                        end
                    end
                end
                MW_RD: begin
                    d.dout  = q.shreg[MW_WORD_W-1];
                    d.shreg = {q.shreg[MW_WORD_W-2:0], 1'b0};
                    d.cnt   = q.cnt - ONE;
                    if (q.cnt == ONE) begin
                        d.state = MW_IDLE;
                    end
                end
                default: d.state = MW_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= MW_IDLE;
            q.cnt   <= '0;
            q.opc   <= '0;
            q.adr   <= '0;
            q.shreg <= '0;
            q.dout  <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.state;
    assign dout_o  = q.dout;
    assign err_o   = q.err;
endmodule

// File: rtl/mw_eeprom_resp.sv
module mw_eeprom_resp
    import mw_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STATION_BYTES = 6,
    parameter int STORE_WORDS   = 12,
    parameter int MAP_BASE      = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sk_i,
    input  logic                       di_i,
    input  logic [8*STATION_BYTES-1:0] station_addr_i,
    output logic                       do_o,
    output logic                       err_o
);
    logic                 sk_rise;
    logic                 di_s;
    logic [MW_WORD_W-1:0] map_word;
    logic                 map_ok;
    logic [MW_ADDR_W-1:0] adr_shift;
    mw_state_e            fsm_state;

    mw_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sk_i   (sk_i),
        .di_i   (di_i),
        .rise_o (sk_rise),
        .di_o   (di_s)
    );

    mw_word_map #(
        .ADDR_W        (MW_ADDR_W),
        .WORD_W        (MW_WORD_W),
        .STATION_BYTES (STATION_BYTES),
        .STORE_WORDS   (STORE_WORDS),
        .BASE_ADDR     (MAP_BASE)
    ) u_map (
        .adr_i     (adr_shift),
        .station_i (station_addr_i),
        .word_o    (map_word),
        .ok_o      (map_ok)
    );

    mw_serial_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (sk_rise),
        .di_i        (di_s),
        .map_word_i  (map_word),
        .map_ok_i    (map_ok),
        .adr_shift_o (adr_shift),
        .state_o     (fsm_state),
        .dout_o      (do_o),
        .err_o       (err_o)
    );
endmodule

// File: rtl/mw_eeprom_resp_chk.sv
module mw_eeprom_resp_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      rise,
    input logic      di_s,
    input mw_state_e state,
    input logic      do_o,
    input logic      err_o
);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R10
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(do_o));

    // R8
    dout_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && state != MW_RD) |=> !do_o);

    // R3
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(rise) &&
                          ($past(state) == MW_OPC || $past(state) == MW_ADR)));

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && state == MW_IDLE && di_s) |=> (state == MW_OPC));
endmodule

bind mw_eeprom_resp mw_eeprom_resp_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rise  (sk_rise),
    .di_s  (di_s),
    .state (fsm_state),
    .do_o  (do_o),
    .err_o (err_o)
);

// File: tb/tb_mw_eeprom_resp.sv
module tb_mw_eeprom_resp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sk_i = 1'b0;
    logic        di_i = 1'b0;
    logic [47:0] station_addr_i = '0;
    logic        do_o;
    logic        err_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        bit    val;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event bit_done;

    always #10 clk = ~clk;

    mw_eeprom_resp dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sk_i           (sk_i),
        .di_i           (di_i),
        .station_addr_i (station_addr_i),
        .do_o           (do_o),
        .err_o          (err_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected data-out level per serial edge
    initial begin
        forever begin
            @(bit_done);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(do_o === e.val, e.tag, int'(do_o), int'(e.val));
            end
        end
    end

    // driver: one serial clock period, then queue the expected do_o level
    task automatic send_bit(input bit b, input bit exp, input string tag, input int hi_len = 4);
        @(negedge clk);
        di_i = b;
        sk_i = 1'b0;
        repeat (4) @(negedge clk);
        sk_i = 1'b1;
        repeat (hi_len) @(negedge clk);
        exp_q.push_back('{exp, tag});
        -> bit_done;
    endtask

    function automatic logic [15:0] exp_word(input int a, input logic [47:0] st);
        case (a)
            8: return st[47:32];
            7: return st[31:16];
            6: return st[15:0];
            default: return 16'h0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sk_i = 1'b0;
        di_i = 1'b0;
        repeat (4) @(negedge clk);
        check(do_o === 1'b0, "R1 do_o in reset", int'(do_o), 0);
        check(err_o === 1'b0, "R1 err_o in reset", int'(err_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // full command; mode 0 plain, 1 di noise during data, 2 station flip, 3 long high phase
    task automatic command(input logic [1:0] op, input logic [5:0] a, input bit ok,
                           input int mode, input string tag);
        logic [15:0] w;
        w = exp_word(int'(a), station_addr_i);
        send_bit(1'b1, 1'b0, {tag, " R2 start"});
        for (int i = 1; i >= 0; i--) send_bit(op[i], 1'b0, {tag, " R3 opcode"});
        for (int i = 5; i >= 0; i--)
            send_bit(a[i], 1'b0, {tag, " R4 address"}, (mode == 3) ? 24 : 4);
        if (mode == 2) station_addr_i = ~station_addr_i;
        if (ok) begin
            for (int i = 15; i >= 0; i--)
                send_bit((mode == 1) ? 1'(i % 2) : 1'b0, w[i], {tag, " R7 data"});
        end
    endtask

    task automatic idle_bits(input int n, input string tag);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0, tag);
    endtask

    initial begin
        do_reset();

        station_addr_i = 48'hA1B2_C3D4_E5F6;
        idle_bits(3, "R2 zeros before start");
        command(2'b10, 6'd8, 1'b1, 0, "R4 addr8");
        idle_bits(1, "R8 drain after word");
        // R11 back to back: start bit shares the draining edge
        command(2'b10, 6'd7, 1'b1, 0, "R11 addr7");
        command(2'b10, 6'd6, 1'b1, 0, "R11 addr6");
        idle_bits(2, "R8 idle low");
        command(2'b10, 6'd8, 1'b1, 1, "R7 di noise");
        idle_bits(1, "R8 drain");
        station_addr_i = 48'h0F1E_2D3C_4B5A;
        command(2'b10, 6'd7, 1'b1, 2, "R7 station flip");
        idle_bits(1, "R8 drain");
        command(2'b10, 6'd6, 1'b1, 3, "R10 long high");
        idle_bits(1, "R8 drain");
        check(err_o === 1'b0, "R10 no error after clean reads", int'(err_o), 0);

        // R10 falling edge alone and a held level change nothing
        @(negedge clk); sk_i = 1'b0; repeat (30) @(negedge clk);
        check(do_o === 1'b0 && err_o === 1'b0, "R10 low level", int'({err_o, do_o}), 0);

        command(2'b11, 6'd8, 1'b0, 0, "R3 opcode 11");
        check(err_o === 1'b1, "R3 bad opcode sets err", int'(err_o), 1);
        idle_bits(4, "R3 no data after bad opcode");
        command(2'b10, 6'd8, 1'b1, 0, "R9 read after error");
        idle_bits(1, "R8 drain");
        check(err_o === 1'b1, "R9 err sticky", int'(err_o), 1);

        do_reset();
        check(err_o === 1'b0, "R1 err cleared by reset", int'(err_o), 0);
        command(2'b01, 6'd8, 1'b0, 0, "R3 opcode 01");
        check(err_o === 1'b1, "R3 opcode 01 sets err", int'(err_o), 1);

        do_reset();
        command(2'b10, 6'd40, 1'b0, 0, "R5 addr 40");
        idle_bits(3, "R5 no data");
        check(err_o === 1'b1, "R5 out of range sets err", int'(err_o), 1);

        do_reset();
        command(2'b10, 6'd3, 1'b0, 0, "R6 addr 3");
        idle_bits(3, "R6 no data");
        check(err_o === 1'b1, "R6 unmapped sets err", int'(err_o), 1);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule